// File: doc/BRIEF.md
# Configurable Logic Cell Column

This block models a vertical stack of logic cells like those found inside a programmable logic block. Each cell pairs a four-input lookup table with a majority-function carry unit and a single-bit register. The carry ripples upward from the bottom cell to the top cell, and the top cell's carry is brought out as a port. Everything about a cell is fixed at elaboration time: its 16-bit table contents, whether the top table input is taken from the carry chain, the register's clock edge, whether it has a clock enable, and whether it has a synchronous or asynchronous set or reset.

A per-cell output select picks the lookup result directly or the registered copy of it, so one column can mix pure logic, pipelined logic and adder slices. A cell used as an adder bit routes its two operands to table inputs I1 and I2, takes the running carry on I3 and uses the carry unit for the carry. The register always loads the cell's lookup result.

Top module: `lcc_column`

## Requirements
- R1: The column has N cells (default 8); cell c takes lut_in[4c+k] as its table input Ik (k = 0..3) and drives cell_out[c].
- R2: A cell's lookup result is bit {I3,I2,I1,I0} of its 16-bit table, with I0 as the least significant index bit.
- R3: Each carry unit outputs the majority of I1, I2 and its carry in; cell 0's carry in is cin, cell c+1's carry in is cell c's carry out, and cout is the carry out of cell N-1.
- R4: When a cell's CARRY_AS_I3 bit is set, its table input I3 is its carry in and lut_in[4c+3] has no effect on that cell.
- R5: When a cell's REG_OUT bit is set, cell_out[c] is the register output; otherwise it is the lookup result, combinationally. The register's data input is always the lookup result.
- R6: A cell whose FALL_EDGE bit is set updates on the falling clock edge; otherwise on the rising edge.
- R7: When a cell's HAS_EN bit is set, a low cell_en[c] at the active edge keeps the stored value; without HAS_EN, cell_en[c] has no effect.
- R8: An active-high cell_ctl[c] forces the register to 0 when HAS_RST is set and to 1 when HAS_SET is set, overriding the enable; a cell asking for both stops elaboration with an error; with neither, cell_ctl[c] has no effect.
- R9: When a cell's ASYNC_CTL bit is set, its set or reset takes effect at once without a clock edge and holds while asserted; otherwise it acts only at the cell's active edge.
- R10: Every register holds 0 at power-up, before any clock edge, whatever its configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all cell registers |
| lut_in | input | 4*N | Table inputs, four per cell, I0 lowest |
| cin | input | 1 | Carry into cell 0 |
| cell_en | input | N | Per-cell register clock enable |
| cell_ctl | input | N | Per-cell set or reset request, active high |
| cell_out | output | N | Per-cell output, lookup or registered |
| cout | output | 1 | Carry out of the top cell |

## Verification
Lookup results and the carry are due as soon as the inputs settle, so the bench compares them one time unit after each input change, long before either clock edge. A registered result is due only after its own cell's active edge, so each period is checked three times: after the inputs change (where only asynchronous set or reset may already have acted), just after the falling edge and just after the rising edge. Inputs change only one time unit after a rising edge, so every cell sees stable inputs at both of its candidate edges, and the bench's model applies each cell's update at the edge that cell is configured for.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int TBL_W = 16;
  localparam int LUT_IN = 4;

  // Table lookup: bit of the table addressed by the four inputs
  function automatic logic lut_pick(input logic [TBL_W-1:0] tbl, input logic [LUT_IN-1:0] idx);
    return tbl[idx];
  endfunction

  // Carry unit: majority of three
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (c & a);
  endfunction
endpackage

// File: rtl/lcc_lut.sv
module lcc_lut #(
  parameter logic [lcc_pkg::TBL_W-1:0] TABLE = '0
) (
  input  logic [lcc_pkg::LUT_IN-1:0] idx,
  output logic                       o
);
  assign o = lcc_pkg::lut_pick(TABLE, idx);
endmodule

// File: rtl/lcc_carry.sv
module lcc_carry (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic co
);
  assign co = lcc_pkg::maj3(a, b, ci);
endmodule

// File: rtl/lcc_dff.sv
module lcc_dff #(
  parameter bit FALL    = 1'b0,
  parameter bit HAS_EN  = 1'b0,
  parameter bit HAS_RST = 1'b0,
  parameter bit HAS_SET = 1'b0,
  parameter bit ASYNC   = 1'b0
) (
  input  logic clk,
  input  logic en,
  input  logic ctl,
  input  logic d,
  output logic q
);
  localparam bit HAS_CTL = HAS_RST | HAS_SET;
  localparam logic CTL_VAL = HAS_SET;

  logic q_r = 1'b0;
  logic ctl_hit;
  logic load;
  logic nxt;

  if (HAS_RST && HAS_SET) begin : g_bad_cfg
    $error("lcc_dff: set and reset requested together");
  end

  assign ctl_hit = HAS_CTL && ctl;
  assign load    = !HAS_EN || en;

  always_comb begin
    if (ctl_hit)   nxt = CTL_VAL;
    else if (load) nxt = d;
    else           nxt = q_r;
  end

  if (HAS_CTL && ASYNC) begin : g_async
    if (FALL) begin : g_neg
      always_ff @(negedge clk or posedge ctl) begin
        if (ctl) q_r <= CTL_VAL;
        else     q_r <= nxt;
      end
    end else begin : g_pos
      always_ff @(posedge clk or posedge ctl) begin
        if (ctl) q_r <= CTL_VAL;
        else     q_r <= nxt;
      end
    end
  end else begin : g_sync
    if (FALL) begin : g_neg
      always_ff @(negedge clk) q_r <= nxt;
    end else begin : g_pos
      always_ff @(posedge clk) q_r <= nxt;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell #(
  parameter logic [lcc_pkg::TBL_W-1:0] TABLE = '0,
  parameter bit CARRY_I3 = 1'b0,
  parameter bit OUT_REG  = 1'b0,
  parameter bit FALL     = 1'b0,
  parameter bit HAS_EN   = 1'b0,
  parameter bit HAS_RST  = 1'b0,
  parameter bit HAS_SET  = 1'b0,
  parameter bit ASYNC    = 1'b0
) (
  input  logic                       clk,
  input  logic [lcc_pkg::LUT_IN-1:0] pins,
  input  logic                       ci,
  input  logic                       en,
  input  logic                       ctl,
  output logic                       co,
  output logic                       q,
  output logic                       o
);
  logic [lcc_pkg::LUT_IN-1:0] idx;
  logic lut_o;

  // I3 comes from the carry chain in adder slices
  assign idx = {(CARRY_I3 ? ci : pins[3]), pins[2:0]};

  lcc_lut #(.TABLE(TABLE)) u_lut (.idx(idx), .o(lut_o));

  lcc_carry u_carry (.a(pins[1]), .b(pins[2]), .ci(ci), .co(co));

  lcc_dff #(
    .FALL(FALL), .HAS_EN(HAS_EN), .HAS_RST(HAS_RST),
    .HAS_SET(HAS_SET), .ASYNC(ASYNC)
  ) u_dff (.clk(clk), .en(en), .ctl(ctl), .d(lut_o), .q(q));

  assign o = OUT_REG ? q : lut_o;
endmodule

// File: rtl/lcc_column.sv
module lcc_column #(
  parameter int N = 8,
  parameter logic [N*16-1:0] CELL_TABLES = {16'h1234, 16'h6996, 16'hFFFE, 16'h8000,
                                            16'hC33C, 16'hC33C, 16'hC33C, 16'hC33C},
  parameter logic [N-1:0] CARRY_AS_I3 = 8'h0F,
  parameter logic [N-1:0] REG_OUT     = 8'hF0,
  parameter logic [N-1:0] FALL_EDGE   = 8'hA0,
  parameter logic [N-1:0] HAS_EN      = 8'hD0,
  parameter logic [N-1:0] HAS_RST     = 8'h50,
  parameter logic [N-1:0] HAS_SET     = 8'hA0,
  parameter logic [N-1:0] ASYNC_CTL   = 8'h60
) (
  input  logic           clk,
  input  logic [N*4-1:0] lut_in,
  input  logic           cin,
  input  logic [N-1:0]   cell_en,
  input  logic [N-1:0]   cell_ctl,
  output logic [N-1:0]   cell_out,
  output logic           cout
);
  localparam int TW = lcc_pkg::TBL_W;
  localparam int KW = lcc_pkg::LUT_IN;

  // Named internal nets for observation
  logic [N:0]   chain;
  logic [N-1:0] reg_q;
  logic [N-1:0] op_a;
  logic [N-1:0] op_b;

  assign chain[0] = cin;

  for (genvar c = 0; c < N; c++) begin : g_cell
    assign op_a[c] = lut_in[c*KW+1];
    assign op_b[c] = lut_in[c*KW+2];

    lcc_cell #(
      .TABLE(CELL_TABLES[c*TW +: TW]),
      .CARRY_I3(CARRY_AS_I3[c]),
      .OUT_REG(REG_OUT[c]),
      .FALL(FALL_EDGE[c]),
      .HAS_EN(HAS_EN[c]),
      .HAS_RST(HAS_RST[c]),
      .HAS_SET(HAS_SET[c]),
      .ASYNC(ASYNC_CTL[c])
    ) u_cell (
      .clk(clk),
      .pins(lut_in[c*KW +: KW]),
      .ci(chain[c]),
      .en(cell_en[c]),
      .ctl(cell_ctl[c]),
      .co(chain[c+1]),
      .q(reg_q[c]),
      .o(cell_out[c])
    );
  end

  assign cout = chain[N];
endmodule

// File: rtl/lcc_column_chk.sv
module lcc_column_chk #(
  parameter int N = 8,
  parameter logic [N-1:0] FALL_EDGE = '0,
  parameter logic [N-1:0] HAS_EN    = '0,
  parameter logic [N-1:0] HAS_RST   = '0,
  parameter logic [N-1:0] HAS_SET   = '0,
  parameter logic [N-1:0] ASYNC_CTL = '0
) (
  input logic         clk,
  input logic         cin,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic [N-1:0] cell_en,
  input logic [N-1:0] cell_ctl,
  input logic [N-1:0] reg_q,
  input logic         cout
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic [N-1:0] gen_v;
  logic [N-1:0] kill_v;
  assign gen_v  = op_a & op_b;
  assign kill_v = ~(op_a | op_b);

  assert_all_generate_R3: assert property (@(posedge clk) disable iff (!armed)
    (&gen_v) |-> cout);
  assert_all_kill_R3: assert property (@(posedge clk) disable iff (!armed)
    (&kill_v) |-> !cout);
  assert_all_propagate_R3: assert property (@(posedge clk) disable iff (!armed)
    ((gen_v | kill_v) == '0) |-> (cout == cin));

  for (genvar c = 0; c < N; c++) begin : g_c
    localparam bit CTL = HAS_RST[c] | HAS_SET[c];
    localparam logic CV = HAS_SET[c];
    if (!FALL_EDGE[c]) begin : g_rise
      if (HAS_EN[c] && !(CTL && ASYNC_CTL[c])) begin : g_hold
        assert_hold_R7: assert property (@(posedge clk) disable iff (!armed)
          (!cell_en[c] && !(CTL && cell_ctl[c])) |=> $stable(reg_q[c]));
      end
      if (CTL && !ASYNC_CTL[c]) begin : g_sctl
        // R8 value, R9 timing
        assert_sync_ctl_R9: assert property (@(posedge clk) disable iff (!armed)
          cell_ctl[c] |=> (reg_q[c] == CV));
      end
      if (CTL && ASYNC_CTL[c]) begin : g_actl
        assert_async_ctl_R9: assert property (@(posedge clk) disable iff (!armed)
          cell_ctl[c] |-> (reg_q[c] == CV));
      end
    end else begin : g_fall
      if (HAS_EN[c] && !(CTL && ASYNC_CTL[c])) begin : g_hold
        assert_hold_R7: assert property (@(negedge clk) disable iff (!armed)
          (!cell_en[c] && !(CTL && cell_ctl[c])) |=> $stable(reg_q[c]));
      end
      if (CTL && !ASYNC_CTL[c]) begin : g_sctl
        // R8 value, R9 timing
        assert_sync_ctl_R9: assert property (@(negedge clk) disable iff (!armed)
          cell_ctl[c] |=> (reg_q[c] == CV));
      end
      if (CTL && ASYNC_CTL[c]) begin : g_actl
        assert_async_ctl_R9: assert property (@(negedge clk) disable iff (!armed)
          cell_ctl[c] |-> (reg_q[c] == CV));
      end
    end
  end
endmodule

bind lcc_column lcc_column_chk #(
  .N(N), .FALL_EDGE(FALL_EDGE), .HAS_EN(HAS_EN), .HAS_RST(HAS_RST),
  .HAS_SET(HAS_SET), .ASYNC_CTL(ASYNC_CTL)
) u_chk (
  .clk(clk), .cin(cin), .op_a(op_a), .op_b(op_b), .cell_en(cell_en),
  .cell_ctl(cell_ctl), .reg_q(reg_q), .cout(cout)
);

// File: tb/sim_lcc_column.sv
module sim_lcc_column;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam logic [N*16-1:0] TBL = {16'h1234, 16'h6996, 16'hFFFE, 16'h8000,
                                     16'hC33C, 16'hC33C, 16'hC33C, 16'hC33C};
  localparam logic [N-1:0] I3C  = 8'h0F;
  localparam logic [N-1:0] OREG = 8'hF0;
  localparam logic [N-1:0] FALL = 8'hA0;
  localparam logic [N-1:0] HEN  = 8'hD0;
  localparam logic [N-1:0] HRST = 8'h50;
  localparam logic [N-1:0] HSET = 8'hA0;
  localparam logic [N-1:0] ASY  = 8'h60;

  logic clk = 1'b0;
  logic [N*4-1:0] lut_in = '0;
  logic cin = 1'b0;
  logic [N-1:0] cell_en = '0;
  logic [N-1:0] cell_ctl = '0;
  wire  [N-1:0] cell_out;
  wire          cout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [N-1:0] mq = '0;
  logic [N-1:0] e_lut;
  logic e_cout;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcc_column #(
    .N(N), .CELL_TABLES(TBL), .CARRY_AS_I3(I3C), .REG_OUT(OREG),
    .FALL_EDGE(FALL), .HAS_EN(HEN), .HAS_RST(HRST), .HAS_SET(HSET), .ASYNC_CTL(ASY)
  ) u0 (
    .clk(clk), .lut_in(lut_in), .cin(cin), .cell_en(cell_en),
    .cell_ctl(cell_ctl), .cell_out(cell_out), .cout(cout)
  );

  function automatic bit f_lut(logic [15:0] t, int idx);
    return ((t >> idx) & 16'd1) != 16'd0;
  endfunction

  function automatic bit f_maj(bit a, bit b, bit c);
    int s = int'(a) + int'(b) + int'(c);
    return s >= 2;
  endfunction

  // Interleave per-cell operand bytes into the lut_in layout
  function automatic logic [N*4-1:0] pack(logic [7:0] i0, logic [7:0] i1,
                                          logic [7:0] i2, logic [7:0] i3);
    logic [N*4-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      v[4*i]   = i0[i];
      v[4*i+1] = i1[i];
      v[4*i+2] = i2[i];
      v[4*i+3] = i3[i];
    end
    return v;
  endfunction

  task automatic model_comb();
    bit c = cin;
    for (int i = 0; i < N; i++) begin
      bit b0 = lut_in[4*i];
      bit b1 = lut_in[4*i+1];
      bit b2 = lut_in[4*i+2];
      bit b3 = I3C[i] ? c : lut_in[4*i+3];
      int idx = 8*int'(b3) + 4*int'(b2) + 2*int'(b1) + int'(b0);
      e_lut[i] = f_lut(TBL[16*i +: 16], idx);
      c = f_maj(b1, b2, c);
    end
    e_cout = c;
  endtask

  task automatic model_edge(bit falling);
    model_comb();
    for (int i = 0; i < N; i++) begin
      if (FALL[i] == falling) begin
        if ((HRST[i] || HSET[i]) && cell_ctl[i]) mq[i] = HSET[i];
        else if (!HEN[i] || cell_en[i])          mq[i] = e_lut[i];
      end
    end
  endtask

  task automatic model_async();
    for (int i = 0; i < N; i++)
      if (ASY[i] && (HRST[i] || HSET[i]) && cell_ctl[i]) mq[i] = HSET[i];
  endtask

  task automatic chk(string tag, logic [N:0] act, logic [N:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    model_comb();
    chk("R1 R2 R3 R4 R5 comb", {cout, cell_out & ~OREG}, {e_cout, e_lut & ~OREG});
    chk("R5 R6 R7 R8 R9 reg", {1'b0, cell_out & OREG}, {1'b0, mq & OREG});
  endtask

  // One clock period; entered and left one time unit after a rising edge
  task automatic step(logic [N*4-1:0] li, logic ci, logic [N-1:0] en, logic [N-1:0] ctl);
    lut_in = li; cin = ci; cell_en = en; cell_ctl = ctl;
    #1;
    model_async();
    check_all();
    @(negedge clk);
    model_edge(1'b1);
    #1;
    check_all();
    @(posedge clk);
    model_edge(1'b0);
    #1;
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    #1;
    // R10: registered outputs are zero before any edge
    chk("R10 power-up", {1'b0, cell_out & OREG}, '0);
    @(posedge clk);
    model_edge(1'b0);
    #1;
    check_all();

    // R3 R4: adder slice 15 + 1, carry propagates through cells 4..7
    step(pack(8'h00, 8'hFF, 8'h01, 8'h00), 1'b0, '0, '0);
    chk("R4 adder F+1", {cout, 4'h0, cell_out[3:0]}, {1'b1, 4'h0, 4'h0});
    // R4: I3 pins of adder cells toggled, no effect
    step(pack(8'h00, 8'hF5, 8'h03, 8'h0F), 1'b1, '0, '0);
    chk("R4 adder 5+3+1", {cout, 4'h0, cell_out[3:0]}, {1'b0, 4'h0, 4'h9});
    // R3: all generate, all kill
    step(pack(8'h00, 8'hFF, 8'hFF, 8'h00), 1'b0, '0, '0);
    chk("R3 generate", {cout, 8'h00}, {1'b1, 8'h00});
    step(pack(8'hFF, 8'h00, 8'h00, 8'hFF), 1'b1, '0, '0);
    chk("R3 kill", {cout, 8'h00}, {1'b0, 8'h00});
    // R9: async set on cell 5 acts before any edge
    lut_in = '0; cell_en = '0; cell_ctl = 8'h20;
    #1;
    chk("R9 async set", {1'b0, 7'h00, cell_out[5]}, {1'b0, 7'h00, 1'b1});
    model_async();
    @(posedge clk); model_edge(1'b0); #1;
    // R7 R8: enable low with all table inputs high, then reset and set
    step(pack(8'hFF, 8'hFF, 8'hFF, 8'hFF), 1'b1, 8'h00, 8'h00);
    step(pack(8'hFF, 8'hFF, 8'hFF, 8'hFF), 1'b1, 8'hFF, 8'h00);
    step(pack(8'hFF, 8'hFF, 8'hFF, 8'hFF), 1'b1, 8'h00, 8'hF0);
    chk("R8 ctl values", {1'b0, cell_out & OREG}, {1'b0, 8'hA0});

    for (int k = 0; k < 400; k++) begin
      logic [N*4-1:0] li = $urandom;
      logic [N-1:0] ct = N'($urandom & $urandom & $urandom);
      step(li, 1'($urandom), N'($urandom), ct);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule